// File: doc/BRIEF.md
# Address Match Trigger Comparator

This block compares a small set of address-match debug triggers against the core's activity in every cycle. Each trigger supplies a control word and a compare address. The control word holds the access kinds to watch (load, store, execute), the privilege levels it applies to, and a watched length for memory accesses. The block also receives the current privilege level, the PC of the instruction about to execute, and an optional load or store with its address and size. When any enabled trigger matches, the block raises a breakpoint-exception request. The request is timed so that the pipeline can trap before the instruction or memory access takes effect.

The request is formed from the inputs sampled in one cycle and is registered by default, so it appears one clock later. The trap value travels with the request. It is the instruction PC for an execute match, or the access address for a memory match. An execute match wins when both kinds match in the same cycle, because the instruction is trapped before its own access. The triggers carry no state of their own. Hit reporting, chaining, data-value compare and any action other than the exception are left to neighbouring logic.

Top module: `trig_addr_match`

## Requirements
- R1: While reset is high, and in the first cycle after reset is sampled, `brk_req` is 0 and `brk_tval` is 0.
- R2: A trigger takes part only if at least one privilege bit (control bits 3, 4, 6) and at least one kind bit (bit 0 load, bit 1 store, bit 2 execute) are set. If either group is all zero, the trigger never matches.
- R3: The privilege input selects control bit 3 + level, where user is 0, supervisor is 1 and machine is 3. A trigger matches only when that bit is 1. Level 2 never matches.
- R4: An execute match requires `exec_valid`, control bit 2, and `exec_pc` equal to the trigger address in every bit.
- R5: A valid access with `mem_store` = 0 (load) matches only if control bit 0 is set. A valid access with `mem_store` = 1 (store) matches only if control bit 1 is set.
- R6: The size code in control bits 17:16 sets the watched length from the trigger address: 1 gives 1 byte, 2 gives 2 bytes, 3 gives 4 bytes, and 0 (any size) gives 8 bytes. With 64-bit addresses, bits 22:21 extend the code, where 5 gives 8 bytes and any unsupported code gives 8 bytes.
- R7: A memory match holds when the access bytes [`mem_addr`, `mem_addr` + 2^`mem_size` − 1] overlap the watched bytes in at least one byte.
- R8: The triggers are ORed, so a match on any one trigger raises the request.
- R9: The request is 1 in the cycle after a cycle that has a valid matching instruction or access, and 0 after every cycle with no valid match. One valid cycle gives a one-cycle pulse.
- R10: With the request, `brk_tval` is the PC for an execute match, else the access address. Execute takes priority over memory. `brk_tval` is 0 when there is no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_ctrl | input | NUM_TRIG x XLEN | Control word per trigger |
| trig_addr | input | NUM_TRIG x XLEN | Compare address per trigger |
| priv_lvl | input | 2 | Current privilege level |
| exec_valid | input | 1 | Instruction about to execute is valid |
| exec_pc | input | XLEN | PC of that instruction |
| mem_valid | input | 1 | Load or store access is valid |
| mem_store | input | 1 | Access kind: 1 store, 0 load |
| mem_addr | input | XLEN | Access start address |
| mem_size | input | 2 | Access size as log2 of bytes |
| brk_req | output | 1 | Breakpoint-exception request |
| brk_tval | output | XLEN | Trap value carried with the request |

## Verification
The bound checker tests five properties on every cycle. Reset clears the output. No request follows a cycle without a valid instruction or access. Privilege level 2 and triggers with no kind bits stay silent. A plain execute match on trigger 0 always gives a request that carries the PC. The directed scenarios cover the rest, since those need chosen operands: the size decode at each byte boundary, partial overlaps from either side, load against store selection, the OR across triggers, and trap value priority when an execute match and a memory match coincide.

// File: rtl/trig_pkg.sv
package trig_pkg;

    // Control word bit positions, shared with the register file that writes them
    localparam int unsigned BIT_LOAD    = 0;
    localparam int unsigned BIT_STORE   = 1;
    localparam int unsigned BIT_EXEC    = 2;
    localparam int unsigned BIT_PRIV0   = 3;
    localparam int unsigned BIT_SZ_LO   = 16;
    localparam int unsigned BIT_SZ_HI   = 21;
    localparam int unsigned LEN_W       = 4;

    typedef enum logic [1:0] {
        PRIV_USER  = 2'd0,
        PRIV_SUPER = 2'd1,
        PRIV_RSVD  = 2'd2,
        PRIV_MACH  = 2'd3
    } priv_e;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_MEM  = 2'd1,
        SRC_EXEC = 2'd2
    } hit_src_e;

    typedef struct packed {
        logic             on_load;
        logic             on_store;
        logic             on_exec;
        logic [3:0]       priv_en;   // indexed by privilege level
        logic [LEN_W-1:0] len;       // watched bytes for memory accesses
    } trig_cfg_t;

    // Size code to watched length; unsupported codes fall back to any-size
    function automatic logic [LEN_W-1:0] size_to_len(input logic [3:0] code);
        logic [LEN_W-1:0] len;
        case (code)
            4'd1:    len = 4'd1;
            4'd2:    len = 4'd2;
            4'd3:    len = 4'd4;
            4'd5:    len = 4'd8;
            default: len = 4'd8;
        endcase
        return len;
    endfunction

    function automatic logic priv_allowed(input logic [3:0] en, input priv_e lvl);
        return en[lvl];
    endfunction

    function automatic logic cfg_enabled(input trig_cfg_t cfg);
        return (|cfg.priv_en) && (cfg.on_load || cfg.on_store || cfg.on_exec);
    endfunction

endpackage

// File: rtl/trig_cfg_decode.sv
module trig_cfg_decode
    import trig_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic [XLEN-1:0] ctrl,
    output trig_cfg_t       cfg
);

    logic [3:0] size_code;
    logic       unused_ctrl;

    generate
        if (XLEN >= 64) begin : g_wide
            assign size_code = {ctrl[BIT_SZ_HI+1:BIT_SZ_HI], ctrl[BIT_SZ_LO+1:BIT_SZ_LO]};
        end else begin : g_narrow
            assign size_code = {2'b00, ctrl[BIT_SZ_LO+1:BIT_SZ_LO]};
        end
    endgenerate

    always_comb begin
        cfg          = '0;
        cfg.on_load  = ctrl[BIT_LOAD];
        cfg.on_store = ctrl[BIT_STORE];
        cfg.on_exec  = ctrl[BIT_EXEC];
        // level 2 has no enable bit
        cfg.priv_en  = {ctrl[BIT_PRIV0+3], 1'b0, ctrl[BIT_PRIV0+1], ctrl[BIT_PRIV0]};
        cfg.len      = size_to_len(size_code);
    end

    assign unused_ctrl = ^ctrl;

endmodule

// File: rtl/trig_cmp.sv
module trig_cmp
    import trig_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  trig_cfg_t       cfg,
    input  logic [XLEN-1:0] tdata2,
    input  priv_e           lvl,
    input  logic            exec_valid,
    input  logic [XLEN-1:0] exec_pc,
    input  logic            mem_valid,
    input  logic            mem_store,
    input  logic [XLEN-1:0] mem_addr,
    input  logic [1:0]      mem_size,
    output logic            hit_exec,
    output logic            hit_mem
);

    // Extended width so that range ends near the top of memory do not wrap
    localparam int unsigned EW = XLEN + LEN_W + 1;

    logic          armed;
    logic          kind_ok;
    logic [EW-1:0] acc_lo, acc_hi, win_lo, win_hi;
    logic          overlap;

    assign armed   = cfg_enabled(cfg) && priv_allowed(cfg.priv_en, lvl);
    assign kind_ok = mem_store ? cfg.on_store : cfg.on_load;

    always_comb begin
        acc_lo  = EW'(mem_addr);
        acc_hi  = acc_lo + (EW'(1) << mem_size);
        win_lo  = EW'(tdata2);
        win_hi  = win_lo + EW'(cfg.len);
        overlap = (acc_lo < win_hi) && (win_lo < acc_hi);
    end

    assign hit_exec = armed && exec_valid && cfg.on_exec && (exec_pc == tdata2);
    assign hit_mem  = armed && mem_valid && kind_ok && overlap;

endmodule

// File: rtl/trig_addr_match.sv
module trig_addr_match
    import trig_pkg::*;
#(
    parameter int unsigned XLEN     = 32,
    parameter int unsigned NUM_TRIG = 2,
    parameter bit          REG_OUT  = 1'b1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_TRIG-1:0][XLEN-1:0] trig_ctrl,
    input  logic [NUM_TRIG-1:0][XLEN-1:0] trig_addr,
    input  logic [1:0]                    priv_lvl,
    input  logic                          exec_valid,
    input  logic [XLEN-1:0]               exec_pc,
    input  logic                          mem_valid,
    input  logic                          mem_store,
    input  logic [XLEN-1:0]               mem_addr,
    input  logic [1:0]                    mem_size,
    output logic                          brk_req,
    output logic [XLEN-1:0]               brk_tval
);

    trig_cfg_t [NUM_TRIG-1:0] cfg;
    logic      [NUM_TRIG-1:0] hit_exec;
    logic      [NUM_TRIG-1:0] hit_mem;
    priv_e                    lvl;
    hit_src_e                 src;
    logic                     req_d;
    logic      [XLEN-1:0]     tval_d;

    assign lvl = priv_e'(priv_lvl);

    generate
        for (genvar t = 0; t < NUM_TRIG; t++) begin : g_trig
            trig_cfg_decode #(.XLEN(XLEN)) dec_i (
                .ctrl (trig_ctrl[t]),
                .cfg  (cfg[t])
            );
            trig_cmp #(.XLEN(XLEN)) cmp_i (
                .cfg        (cfg[t]),
                .tdata2     (trig_addr[t]),
                .lvl        (lvl),
                .exec_valid (exec_valid),
                .exec_pc    (exec_pc),
                .mem_valid  (mem_valid),
                .mem_store  (mem_store),
                .mem_addr   (mem_addr),
                .mem_size   (mem_size),
                .hit_exec   (hit_exec[t]),
                .hit_mem    (hit_mem[t])
            );
        end
    endgenerate

    // Instruction trap is taken before its own access
    always_comb begin
        if (|hit_exec)      src = SRC_EXEC;
        else if (|hit_mem)  src = SRC_MEM;
        else                src = SRC_NONE;
        req_d = (src != SRC_NONE);
        case (src)
            SRC_EXEC: tval_d = exec_pc;
            SRC_MEM:  tval_d = mem_addr;
            default:  tval_d = '0;
        endcase
    end

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    brk_req  <= 1'b0;
                    brk_tval <= '0;
                end else begin
                    brk_req  <= req_d;
                    brk_tval <= tval_d;
                end
            end
        end else begin : g_comb
            assign brk_req  = req_d;
            assign brk_tval = tval_d;
        end
    endgenerate

endmodule

// File: rtl/trig_addr_match_chk.sv
module trig_addr_match_chk #(
    parameter int unsigned XLEN     = 32,
    parameter int unsigned NUM_TRIG = 2
) (
    input logic                          clk,
    input logic                          rst,
    input logic [NUM_TRIG-1:0][XLEN-1:0] trig_ctrl,
    input logic [NUM_TRIG-1:0][XLEN-1:0] trig_addr,
    input logic [1:0]                    priv_lvl,
    input logic                          exec_valid,
    input logic [XLEN-1:0]               exec_pc,
    input logic                          mem_valid,
    input logic                          brk_req,
    input logic [XLEN-1:0]               brk_tval
);

    logic no_kinds;
    always_comb begin
        no_kinds = 1'b1;
        for (int t = 0; t < NUM_TRIG; t++) begin
            if (trig_ctrl[t][2:0] != 3'b000) no_kinds = 1'b0;
        end
    end

    // R1: output cleared after a reset cycle
    p_reset_clear_r1: assert property (@(posedge clk)
        $past(rst) |-> (!brk_req && brk_tval == '0));

    // R9: no request without a valid instruction or access
    p_no_valid_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (!exec_valid && !mem_valid) |=> !brk_req);

    // R3: reserved privilege level never fires
    p_rsvd_priv_r3: assert property (@(posedge clk) disable iff (rst)
        (priv_lvl == 2'd2) |=> !brk_req);

    // R2: triggers without any kind bit stay silent
    p_no_kind_r2: assert property (@(posedge clk) disable iff (rst)
        no_kinds |=> !brk_req);

    // R4: execute match on trigger 0 raises request carrying the PC
    p_exec_hit_r4: assert property (@(posedge clk) disable iff (rst)
        (exec_valid && trig_ctrl[0][2] && priv_lvl != 2'd2 &&
         trig_ctrl[0][3 + priv_lvl] && exec_pc == trig_addr[0])
        |=> (brk_req && brk_tval == $past(exec_pc)));

endmodule

bind trig_addr_match trig_addr_match_chk #(
    .XLEN     (XLEN),
    .NUM_TRIG (NUM_TRIG)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .trig_ctrl  (trig_ctrl),
    .trig_addr  (trig_addr),
    .priv_lvl   (priv_lvl),
    .exec_valid (exec_valid),
    .exec_pc    (exec_pc),
    .mem_valid  (mem_valid),
    .brk_req    (brk_req),
    .brk_tval   (brk_tval)
);

// File: tb/trig_addr_match_tb_top.sv
`timescale 1ns/1ps
module trig_addr_match_tb_top;

    localparam int XLEN = 32;
    localparam int NT   = 2;

    logic                    clk = 1'b0;
    logic                    rst;
    logic [NT-1:0][XLEN-1:0] trig_ctrl;
    logic [NT-1:0][XLEN-1:0] trig_addr;
    logic [1:0]              priv_lvl;
    logic                    exec_valid;
    logic [XLEN-1:0]         exec_pc;
    logic                    mem_valid;
    logic                    mem_store;
    logic [XLEN-1:0]         mem_addr;
    logic [1:0]              mem_size;
    logic                    brk_req;
    logic [XLEN-1:0]         brk_tval;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    trig_addr_match #(.XLEN(XLEN), .NUM_TRIG(NT)) dut_i (
        .clk(clk), .rst(rst), .trig_ctrl(trig_ctrl), .trig_addr(trig_addr),
        .priv_lvl(priv_lvl), .exec_valid(exec_valid), .exec_pc(exec_pc),
        .mem_valid(mem_valid), .mem_store(mem_store), .mem_addr(mem_addr),
        .mem_size(mem_size), .brk_req(brk_req), .brk_tval(brk_tval)
    );

    // kinds: bit0 load, bit1 store, bit2 exec; privs: {M,S,U}
    function automatic logic [31:0] mk(input logic [2:0] privs, input logic [2:0] kinds,
                                       input logic [1:0] sz);
        return {14'd0, sz, 9'd0, privs[2], 1'b0, privs[1], privs[0], kinds};
    endfunction

    task automatic check(input string req, input logic exp_req, input logic [31:0] exp_tval);
        n_chk++;
        if (brk_req !== exp_req || brk_tval !== exp_tval) begin
            n_fail++;
            $display("FAIL %s: req=%0b tval=%h expected req=%0b tval=%h",
                     req, brk_req, brk_tval, exp_req, exp_tval);
        end
    endtask

    task automatic idle();
        exec_valid = 0; exec_pc = '0; mem_valid = 0; mem_store = 0;
        mem_addr = '0; mem_size = '0;
    endtask

    // apply at a falling edge, result sampled at the next falling edge
    task automatic step_exec(input logic [31:0] pc);
        idle(); exec_valid = 1; exec_pc = pc;
        @(negedge clk);
    endtask

    task automatic step_mem(input logic st, input logic [31:0] a, input logic [1:0] sz);
        idle(); mem_valid = 1; mem_store = st; mem_addr = a; mem_size = sz;
        @(negedge clk);
    endtask

    task automatic set_trig(input int t, input logic [31:0] c, input logic [31:0] a);
        trig_ctrl[t] = c; trig_addr[t] = a;
    endtask

    task automatic clear_trigs();
        trig_ctrl = '0; trig_addr = '0;
    endtask

    task automatic t_reset();
        clear_trigs(); idle(); priv_lvl = 2'd3;
        set_trig(0, mk(3'b111, 3'b100, 2'd0), 32'h0);
        exec_valid = 1; exec_pc = 32'h0;
        rst = 1;
        @(negedge clk); check("R1", 1'b0, 32'h0);
        @(negedge clk); check("R1", 1'b0, 32'h0);
        rst = 0;
        idle();
        @(negedge clk);
    endtask

    task automatic t_exec();
        clear_trigs(); priv_lvl = 2'd3;
        set_trig(0, mk(3'b100, 3'b100, 2'd0), 32'h1000);
        step_exec(32'h1000); check("R4", 1'b1, 32'h1000);
        step_exec(32'h1004); check("R4", 1'b0, 32'h0);
        step_exec(32'h1001); check("R4", 1'b0, 32'h0);
    endtask

    task automatic t_priv();
        clear_trigs();
        set_trig(0, mk(3'b001, 3'b100, 2'd0), 32'h1100);
        priv_lvl = 2'd3; step_exec(32'h1100); check("R3", 1'b0, 32'h0);
        priv_lvl = 2'd0; step_exec(32'h1100); check("R3", 1'b1, 32'h1100);
        set_trig(0, mk(3'b111, 3'b100, 2'd0), 32'h1100);
        priv_lvl = 2'd2; step_exec(32'h1100); check("R3", 1'b0, 32'h0);
        set_trig(0, mk(3'b010, 3'b100, 2'd0), 32'h1100);
        priv_lvl = 2'd1; step_exec(32'h1100); check("R3", 1'b1, 32'h1100);
        priv_lvl = 2'd0; step_exec(32'h1100); check("R3", 1'b0, 32'h0);
    endtask

    task automatic t_enable();
        clear_trigs(); priv_lvl = 2'd3;
        set_trig(0, mk(3'b100, 3'b000, 2'd0), 32'h1200);
        step_exec(32'h1200); check("R2", 1'b0, 32'h0);
        step_mem(1'b0, 32'h1200, 2'd2); check("R2", 1'b0, 32'h0);
        set_trig(0, mk(3'b000, 3'b111, 2'd0), 32'h1200);
        step_exec(32'h1200); check("R2", 1'b0, 32'h0);
        step_mem(1'b1, 32'h1200, 2'd2); check("R2", 1'b0, 32'h0);
    endtask

    task automatic t_kinds();
        clear_trigs(); priv_lvl = 2'd3;
        set_trig(0, mk(3'b100, 3'b001, 2'd3), 32'h2000);
        step_mem(1'b0, 32'h2000, 2'd0); check("R5", 1'b1, 32'h2000);
        step_mem(1'b1, 32'h2000, 2'd0); check("R5", 1'b0, 32'h0);
        step_exec(32'h2000);             check("R5", 1'b0, 32'h0);
        set_trig(0, mk(3'b100, 3'b010, 2'd3), 32'h2000);
        step_mem(1'b1, 32'h2002, 2'd0); check("R5", 1'b1, 32'h2002);
        step_mem(1'b0, 32'h2002, 2'd0); check("R5", 1'b0, 32'h0);
    endtask

    task automatic t_sizes();
        clear_trigs(); priv_lvl = 2'd3;
        set_trig(0, mk(3'b100, 3'b001, 2'd1), 32'h3000);
        step_mem(1'b0, 32'h3000, 2'd0); check("R6", 1'b1, 32'h3000);
        step_mem(1'b0, 32'h3001, 2'd0); check("R6", 1'b0, 32'h0);
        set_trig(0, mk(3'b100, 3'b001, 2'd2), 32'h3000);
        step_mem(1'b0, 32'h3001, 2'd0); check("R6", 1'b1, 32'h3001);
        step_mem(1'b0, 32'h3002, 2'd0); check("R6", 1'b0, 32'h0);
        set_trig(0, mk(3'b100, 3'b001, 2'd3), 32'h3000);
        step_mem(1'b0, 32'h3003, 2'd0); check("R6", 1'b1, 32'h3003);
        step_mem(1'b0, 32'h3004, 2'd0); check("R6", 1'b0, 32'h0);
        set_trig(0, mk(3'b100, 3'b001, 2'd0), 32'h3000);
        step_mem(1'b0, 32'h3007, 2'd0); check("R6", 1'b1, 32'h3007);
        step_mem(1'b0, 32'h3008, 2'd0); check("R6", 1'b0, 32'h0);
    endtask

    task automatic t_overlap();
        clear_trigs(); priv_lvl = 2'd3;
        set_trig(0, mk(3'b100, 3'b011, 2'd1), 32'h4003);
        step_mem(1'b0, 32'h4000, 2'd2); check("R7", 1'b1, 32'h4000);
        step_mem(1'b1, 32'h4004, 2'd2); check("R7", 1'b0, 32'h0);
        step_mem(1'b1, 32'h3FFC, 2'd3); check("R7", 1'b1, 32'h3FFC);
        step_mem(1'b0, 32'h4002, 2'd0); check("R7", 1'b0, 32'h0);
    endtask

    task automatic t_or();
        clear_trigs(); priv_lvl = 2'd3;
        set_trig(1, mk(3'b100, 3'b100, 2'd0), 32'h5000);
        step_exec(32'h5000); check("R8", 1'b1, 32'h5000);
        set_trig(0, mk(3'b100, 3'b100, 2'd0), 32'h6000);
        step_exec(32'h6000); check("R8", 1'b1, 32'h6000);
        step_exec(32'h5000); check("R8", 1'b1, 32'h5000);
        step_exec(32'h7000); check("R8", 1'b0, 32'h0);
    endtask

    task automatic t_valid();
        clear_trigs(); priv_lvl = 2'd3;
        set_trig(0, mk(3'b100, 3'b101, 2'd0), 32'h7100);
        idle(); exec_pc = 32'h7100; mem_addr = 32'h7100;
        @(negedge clk); check("R9", 1'b0, 32'h0);
        step_exec(32'h7100); check("R9", 1'b1, 32'h7100);
        idle(); exec_pc = 32'h7100;
        @(negedge clk); check("R9", 1'b0, 32'h0);
    endtask

    task automatic t_tval();
        clear_trigs(); priv_lvl = 2'd3;
        set_trig(0, mk(3'b100, 3'b100, 2'd0), 32'h8000);
        set_trig(1, mk(3'b100, 3'b010, 2'd0), 32'h9000);
        idle(); exec_valid = 1; exec_pc = 32'h8000;
        mem_valid = 1; mem_store = 1; mem_addr = 32'h9000; mem_size = 2'd2;
        @(negedge clk); check("R10", 1'b1, 32'h8000);
        step_mem(1'b1, 32'h9004, 2'd2); check("R10", 1'b1, 32'h9004);
        idle(); exec_valid = 1; exec_pc = 32'h8004;
        mem_valid = 1; mem_store = 1; mem_addr = 32'h9000; mem_size = 2'd0;
        @(negedge clk); check("R10", 1'b1, 32'h9000);
    endtask

    initial begin
        clear_trigs(); idle(); priv_lvl = 2'd3; rst = 1;
        @(negedge clk);
        t_reset();
        t_exec();
        t_priv();
        t_enable();
        t_kinds();
        t_sizes();
        t_overlap();
        t_or();
        t_valid();
        t_tval();
        idle();
        @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule